// File: doc/BRIEF.md
# Word-Packed Serial Receiver with Idle-Line Close

This block takes a single asynchronous serial line carrying 8-N-1 characters, recovers each character with an oversampling state machine, and collects the characters into 32-bit words, four at a time, before storing each word in a small receive queue. Software drains the queue one word per read through a narrow register port, so a burst of traffic costs a quarter of the reads it would cost if each byte were delivered on its own.

A transfer has no length field on the wire. The receiver decides that a transfer has finished when the line has been quiet for a programmable number of character times after the last character. At that moment it raises a stale flag, pushes any half-filled word into the queue with its unused upper bytes cleared, and freezes a copy of the running byte count. Software reads that count to learn how many bytes of the final word are real. A watermark on the queue level and the stale flag together drive one interrupt line; overrun of the queue is reported as a sticky status bit.

Top module: `wpk_uart_rx`

## Requirements
- R1: After reset the STATUS (address 1), ISR (address 2) and TOTAL (address 4) registers read zero and `irq` is low.
- R2: Characters are 8 data bits sent least significant bit first between a low start bit and a high stop bit; while the receiver is disabled (STATUS bit 2 low) arriving characters are discarded and STATUS bit 0 (queue not empty) stays low.
- R3: Four consecutive characters form one queue word read from DATA (address 3), the first character in bits [7:0] and each later one in the next higher byte.
- R4: Once stale detection is armed (command 4) and at least one character has arrived, ISR bit 0 and `irq` go high after the line has been idle for TIMEOUT (address 6) character times; with no character received the flag never sets.
- R5: The stale event pushes a partly filled word into the queue with the unfilled upper bytes equal to zero.
- R6: TOTAL reads the count of characters received since the last receiver reset, captured at the stale event, and keeps that value until the next stale event or receiver reset.
- R7: Command 3 clears ISR bit 0; after a stale event the flag does not set again until command 4 re-arms detection.
- R8: A word arriving while the queue is full (STATUS bit 3) is dropped, the stored words are kept unchanged, and STATUS bit 1 (overrun) sets and stays set until command 5.
- R9: ISR bit 1 and `irq` are high while the number of stored words exceeds WMARK (address 5).
- R10: Command 1 empties the queue, discards a partial word, clears the byte count, the snapshot and the stale flag, and disables the receiver; command 2 enables it.
- R11: A character whose stop bit is sampled low is discarded and does not occupy a byte lane.

Commands are written to CMD (address 0) as the code in bits [2:0].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| baud_tick | input | 1 | Oversample enable, OVS pulses per bit time |
| rx_in | input | 1 | Serial receive line, idle high |
| reg_addr | input | 3 | Register address |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rd | input | 1 | Register read strobe; a read of DATA pops the queue |
| reg_rdata | output | 32 | Register read data, valid in the strobe cycle |
| irq | output | 1 | Stale flag OR watermark condition |

## Verification
The hardest condition to reach from the ports is a word arriving against a full queue while the watermark, overrun and level behaviour all interact, because it needs nine complete words on the serial line with no reads in between and stale detection left unarmed so no early flush disturbs the lane alignment. The bench reaches it by resetting and enabling without arming, streaming thirty-six numbered characters, and checking the watermark bit at the two-word and three-word points on the way. The re-arm rule is reached by clearing the flag, sending a character without arming and waiting well past the timeout, then arming and sending one more so that the flushed word carries both characters.

// File: rtl/wpk_pkg.sv
package wpk_pkg;
   localparam logic [2:0] A_CMD     = 3'd0;
   localparam logic [2:0] A_STATUS  = 3'd1;
   localparam logic [2:0] A_ISR     = 3'd2;
   localparam logic [2:0] A_DATA    = 3'd3;
   localparam logic [2:0] A_TOTAL   = 3'd4;
   localparam logic [2:0] A_WMARK   = 3'd5;
   localparam logic [2:0] A_TIMEOUT = 3'd6;

   localparam logic [2:0] C_RX_RESET  = 3'd1;
   localparam logic [2:0] C_RX_ENABLE = 3'd2;
   localparam logic [2:0] C_STALE_CLR = 3'd3;
   localparam logic [2:0] C_STALE_ARM = 3'd4;
   localparam logic [2:0] C_ERR_CLR   = 3'd5;

   typedef enum logic [1:0] {
      S_IDLE  = 2'd0,
      S_START = 2'd1,
      S_DATA  = 2'd2,
      S_STOP  = 2'd3
   } deser_state_e;
endpackage

// File: rtl/wpk_rx_deser.sv
module wpk_rx_deser #(
   parameter int OVS = 16
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       tick,
   input  logic       rx,
   output logic       byte_vld,
   output logic [7:0] byte_data,
   output logic       busy
);
   import wpk_pkg::*;

   localparam int CNT_W = $clog2(OVS);
   localparam logic [CNT_W-1:0] LAST_T = CNT_W'(OVS - 1);
   localparam logic [CNT_W-1:0] MID_T  = CNT_W'(OVS / 2 - 1);

   deser_state_e     state;
   logic [1:0]       rx_sync;
   logic             rx_s;
   logic [CNT_W-1:0] cnt;
   logic [2:0]       bitn;
   logic [7:0]       shreg;

   assign rx_s      = rx_sync[1];
   assign busy      = (state != S_IDLE);
   assign byte_data = shreg;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rx_sync  <= 2'b11;
         state    <= S_IDLE;
         cnt      <= '0;
         bitn     <= '0;
         shreg    <= '0;
         byte_vld <= 1'b0;
      end else begin
         rx_sync  <= {rx_sync[0], rx};
         byte_vld <= 1'b0;
         case (state)
            S_IDLE: begin
               if (!rx_s) begin
                  state <= S_START;
                  cnt   <= '0;
               end
            end
            S_START: begin
               if (tick) begin
                  if (cnt == MID_T) begin
                     cnt  <= '0;
                     bitn <= '0;
                     state <= rx_s ? S_IDLE : S_DATA;
                  end else begin
                     cnt <= cnt + 1'b1;
                  end
               end
            end
            S_DATA: begin
               if (tick) begin
                  if (cnt == LAST_T) begin
                     cnt   <= '0;
                     shreg <= {rx_s, shreg[7:1]};
                     if (bitn == 3'd7) state <= S_STOP;
                     else              bitn  <= bitn + 1'b1;
                  end else begin
                     cnt <= cnt + 1'b1;
                  end
               end
            end
            default: begin
               if (tick) begin
                  if (cnt == LAST_T) begin
                     byte_vld <= rx_s;
                     state    <= S_IDLE;
                     cnt      <= '0;
                  end else begin
                     cnt <= cnt + 1'b1;
                  end
               end
            end
         endcase
      end
   end
endmodule

// File: rtl/wpk_rx_packer.sv
module wpk_rx_packer #(
   parameter int OVS    = 16,
   parameter int WORD_W = 32,
   parameter int TO_W   = 8,
   parameter int CNT_W  = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              tick,
   input  logic              rx_busy,
   input  logic              byte_vld,
   input  logic [7:0]        byte_data,
   input  logic [TO_W-1:0]   timeout,
   input  logic              arm_set,
   input  logic              stale_clr,
   output logic              push,
   output logic [WORD_W-1:0] push_word,
   output logic              stale_evt,
   output logic              stale_flag,
   output logic [CNT_W-1:0]  total_cnt,
   output logic [CNT_W-1:0]  total_snap
);
   localparam int BPW        = WORD_W / 8;
   localparam int LANE_W     = (BPW > 1) ? $clog2(BPW) : 1;
   localparam int CHAR_TICKS = 10 * OVS;
   localparam int CT_W       = $clog2(CHAR_TICKS);
   localparam logic [LANE_W-1:0] LAST_LANE = LANE_W'(BPW - 1);
   localparam logic [CT_W-1:0]   CHAR_LAST = CT_W'(CHAR_TICKS - 1);

   logic [WORD_W-1:0] acc;
   logic [WORD_W-1:0] merged;
   logic [LANE_W-1:0] lane;
   logic              armed;
   logic              seen;
   logic [CT_W-1:0]   tick_cnt;
   logic [TO_W-1:0]   char_cnt;

   for (genvar g = 0; g < BPW; g++) begin : g_lane
      assign merged[g*8 +: 8] = (lane == LANE_W'(g)) ? byte_data : acc[g*8 +: 8];
   end

   assign stale_evt = armed && seen && !byte_vld && !rx_busy && (char_cnt == timeout);
   assign push      = (byte_vld && (lane == LAST_LANE)) || (stale_evt && (lane != '0));
   assign push_word = byte_vld ? merged : acc;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc <= '0; lane <= '0; armed <= 1'b0; seen <= 1'b0;
         stale_flag <= 1'b0; total_cnt <= '0; total_snap <= '0;
         tick_cnt <= '0; char_cnt <= '0;
      end else if (clr) begin
         acc <= '0; lane <= '0; armed <= 1'b0; seen <= 1'b0;
         stale_flag <= 1'b0; total_cnt <= '0; total_snap <= '0;
         tick_cnt <= '0; char_cnt <= '0;
      end else begin
         if (stale_clr) stale_flag <= 1'b0;
         if (arm_set)   armed      <= 1'b1;
         if (byte_vld) begin
            total_cnt <= total_cnt + 1'b1;
            seen      <= 1'b1;
            if (lane == LAST_LANE) begin
               lane <= '0;
               acc  <= '0;
            end else begin
               lane <= lane + 1'b1;
               acc  <= merged;
            end
         end else if (stale_evt) begin
            lane       <= '0;
            acc        <= '0;
            armed      <= 1'b0;
            seen       <= 1'b0;
            stale_flag <= 1'b1;
            total_snap <= total_cnt;
         end
         if (byte_vld || rx_busy) begin
            tick_cnt <= '0;
            char_cnt <= '0;
         end else if (tick) begin
            if (tick_cnt == CHAR_LAST) begin
               tick_cnt <= '0;
               if (char_cnt != {TO_W{1'b1}}) char_cnt <= char_cnt + 1'b1;
            end else begin
               tick_cnt <= tick_cnt + 1'b1;
            end
         end
      end
   end
endmodule

// File: rtl/wpk_fifo.sv
module wpk_fifo #(
   parameter int W     = 32,
   parameter int DEPTH = 8,
   parameter int LVL_W = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             push,
   input  logic [W-1:0]     wdata,
   input  logic             pop,
   output logic [W-1:0]     rdata,
   output logic             full,
   output logic             empty,
   output logic [LVL_W-1:0] level
);
   localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

   logic [W-1:0]     mem [DEPTH];
   logic [PTR_W-1:0] wr_ptr;
   logic [PTR_W-1:0] rd_ptr;
   logic             wr_ok;
   logic             rd_ok;

   assign full  = (level == LVL_W'(DEPTH));
   assign empty = (level == '0);
   assign wr_ok = push && !full;
   assign rd_ok = pop && !empty;
   assign rdata = mem[rd_ptr];

   always_ff @(posedge clk) begin
      if (wr_ok) mem[wr_ptr] <= wdata;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr <= '0; rd_ptr <= '0; level <= '0;
      end else if (clr) begin
         wr_ptr <= '0; rd_ptr <= '0; level <= '0;
      end else begin
         if (wr_ok) wr_ptr <= wr_ptr + 1'b1;
         if (rd_ok) rd_ptr <= rd_ptr + 1'b1;
         level <= level + LVL_W'(wr_ok) - LVL_W'(rd_ok);
      end
   end
endmodule

// File: rtl/wpk_uart_rx.sv
module wpk_uart_rx #(
   parameter int OVS         = 16,
   parameter int WORD_W      = 32,
   parameter int DEPTH       = 8,
   parameter int TO_W        = 8,
   parameter int CNT_W       = 16,
   parameter int DEF_TIMEOUT = 4
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        baud_tick,
   input  logic        rx_in,
   input  logic [2:0]  reg_addr,
   input  logic        reg_wr,
   input  logic [31:0] reg_wdata,
   input  logic        reg_rd,
   output logic [31:0] reg_rdata,
   output logic        irq
);
   import wpk_pkg::*;

   localparam int LVL_W = $clog2(DEPTH + 1);

   if (OVS < 4 || (OVS % 2) != 0) begin : g_bad_ovs
      $error("OVS must be even and at least 4");
   end
   if (WORD_W != 32) begin : g_bad_word
      $error("WORD_W must match the 32-bit register port");
   end
   if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("DEPTH must be a power of two, at least 2");
   end
   if (TO_W > 32 || CNT_W > 32 || LVL_W > 32) begin : g_bad_width
      $error("register fields wider than the port");
   end

   logic              byte_vld_raw, byte_vld, rx_busy;
   logic [7:0]        byte_data;
   logic              rx_en, overrun;
   logic [LVL_W-1:0]  wm_q;
   logic [TO_W-1:0]   timeout_q;
   logic              cmd_wr, rx_reset, stale_clr, stale_arm, err_clr;
   logic              fifo_push, fifo_pop, fifo_full, fifo_empty;
   logic [WORD_W-1:0] push_word, fifo_head;
   logic [LVL_W-1:0]  fifo_level;
   logic              stale_evt, stale_flag, wm_hit;
   logic [CNT_W-1:0]  total_cnt, total_snap;
   logic              unused_wdata;

   assign unused_wdata = ^reg_wdata;

   assign cmd_wr    = reg_wr && (reg_addr == A_CMD);
   assign rx_reset  = cmd_wr && (reg_wdata[2:0] == C_RX_RESET);
   assign stale_clr = cmd_wr && (reg_wdata[2:0] == C_STALE_CLR);
   assign stale_arm = cmd_wr && (reg_wdata[2:0] == C_STALE_ARM);
   assign err_clr   = cmd_wr && (reg_wdata[2:0] == C_ERR_CLR);
   assign fifo_pop  = reg_rd && (reg_addr == A_DATA) && !fifo_empty;
   assign byte_vld  = byte_vld_raw && rx_en;
   assign wm_hit    = (fifo_level > wm_q);
   assign irq       = stale_flag || wm_hit;

   wpk_rx_deser #(.OVS(OVS)) u_deser (
      .clk(clk), .rst_n(rst_n), .tick(baud_tick), .rx(rx_in),
      .byte_vld(byte_vld_raw), .byte_data(byte_data), .busy(rx_busy)
   );

   wpk_rx_packer #(.OVS(OVS), .WORD_W(WORD_W), .TO_W(TO_W), .CNT_W(CNT_W)) u_packer (
      .clk(clk), .rst_n(rst_n), .clr(rx_reset), .tick(baud_tick),
      .rx_busy(rx_busy), .byte_vld(byte_vld), .byte_data(byte_data),
      .timeout(timeout_q), .arm_set(stale_arm), .stale_clr(stale_clr),
      .push(fifo_push), .push_word(push_word), .stale_evt(stale_evt),
      .stale_flag(stale_flag), .total_cnt(total_cnt), .total_snap(total_snap)
   );

   wpk_fifo #(.W(WORD_W), .DEPTH(DEPTH), .LVL_W(LVL_W)) u_fifo (
      .clk(clk), .rst_n(rst_n), .clr(rx_reset), .push(fifo_push),
      .wdata(push_word), .pop(fifo_pop), .rdata(fifo_head),
      .full(fifo_full), .empty(fifo_empty), .level(fifo_level)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rx_en     <= 1'b0;
         overrun   <= 1'b0;
         wm_q      <= LVL_W'(DEPTH);
         timeout_q <= TO_W'(DEF_TIMEOUT);
      end else begin
         if (rx_reset)
            rx_en <= 1'b0;
         else if (cmd_wr && (reg_wdata[2:0] == C_RX_ENABLE))
            rx_en <= 1'b1;
         if (err_clr) overrun <= 1'b0;
         if (fifo_push && fifo_full) overrun <= 1'b1;
         if (reg_wr && (reg_addr == A_WMARK))   wm_q      <= reg_wdata[LVL_W-1:0];
         if (reg_wr && (reg_addr == A_TIMEOUT)) timeout_q <= reg_wdata[TO_W-1:0];
      end
   end

   always_comb begin
      reg_rdata = '0;
      case (reg_addr)
         A_STATUS:  reg_rdata[3:0] = {fifo_full, rx_en, overrun, !fifo_empty};
         A_ISR:     reg_rdata[1:0] = {wm_hit, stale_flag};
         A_DATA:    reg_rdata = fifo_head;
         A_TOTAL:   reg_rdata[CNT_W-1:0] = total_snap;
         A_WMARK:   reg_rdata[LVL_W-1:0] = wm_q;
         A_TIMEOUT: reg_rdata[TO_W-1:0] = timeout_q;
         default:   reg_rdata = '0;
      endcase
   end
endmodule

// File: rtl/wpk_uart_rx_chk.sv
module wpk_uart_rx_chk #(
   parameter int DEPTH = 8,
   parameter int LVL_W = 4,
   parameter int CNT_W = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic             fifo_push,
   input logic             fifo_pop,
   input logic             fifo_full,
   input logic [LVL_W-1:0] fifo_level,
   input logic [LVL_W-1:0] wm_q,
   input logic             overrun,
   input logic             rx_reset,
   input logic             stale_evt,
   input logic             stale_flag,
   input logic [CNT_W-1:0] total_cnt,
   input logic [CNT_W-1:0] total_snap,
   input logic             irq
);
   AST_OVERRUN_SET: assert property (@(posedge clk) disable iff (!rst_n)
      (fifo_push && fifo_full) |=> overrun); // R8
   AST_FULL_KEEPS_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
      (fifo_push && fifo_full && !fifo_pop && !rx_reset) |=> (fifo_level == LVL_W'(DEPTH))); // R8
   AST_LEVEL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      fifo_level <= LVL_W'(DEPTH)); // R8
   AST_STALE_NEEDS_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(stale_flag) |-> (total_cnt != '0)); // R4
   AST_SNAP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!stale_evt && !rx_reset) |=> $stable(total_snap)); // R6
   AST_RESET_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
      rx_reset |=> (fifo_level == '0 && !stale_flag)); // R10
   AST_WMARK_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
      (fifo_level > wm_q) |-> irq); // R9
endmodule

bind wpk_uart_rx wpk_uart_rx_chk #(.DEPTH(DEPTH), .LVL_W(LVL_W), .CNT_W(CNT_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .fifo_push(fifo_push), .fifo_pop(fifo_pop),
   .fifo_full(fifo_full), .fifo_level(fifo_level), .wm_q(wm_q),
   .overrun(overrun), .rx_reset(rx_reset), .stale_evt(stale_evt),
   .stale_flag(stale_flag), .total_cnt(total_cnt), .total_snap(total_snap),
   .irq(irq)
);

// File: tb/wpk_uart_rx_tb.sv
module wpk_uart_rx_tb;
   localparam int BIT_CLKS = 16;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        baud_tick = 1'b1;
   logic        rx_in = 1'b1;
   logic [2:0]  reg_addr = '0;
   logic        reg_wr = 1'b0;
   logic [31:0] reg_wdata = '0;
   logic        reg_rd = 1'b0;
   logic [31:0] reg_rdata;
   logic        irq;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   wpk_uart_rx u_dut (
      .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .rx_in(rx_in),
      .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
      .reg_rd(reg_rd), .reg_rdata(reg_rdata), .irq(irq)
   );

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic wr_reg(input logic [2:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd_reg(input logic [2:0] a, output logic [31:0] d);
      @(negedge clk);
      reg_addr = a; reg_rd = 1'b1;
      #1 d = reg_rdata;
      @(negedge clk);
      reg_rd = 1'b0;
   endtask

   task automatic send_frame(input logic [7:0] b, input logic stop);
      @(negedge clk);
      rx_in = 1'b0;
      repeat (BIT_CLKS) @(negedge clk);
      for (int i = 0; i < 8; i++) begin
         rx_in = b[i];
         repeat (BIT_CLKS) @(negedge clk);
      end
      rx_in = stop;
      repeat (BIT_CLKS) @(negedge clk);
      rx_in = 1'b1;
      if (!stop) repeat (BIT_CLKS) @(negedge clk);
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic start_transfer(input bit arm);
      wr_reg(3'd0, 32'd1);
      wr_reg(3'd0, 32'd2);
      wr_reg(3'd0, 32'd3);
      if (arm) wr_reg(3'd0, 32'd4);
   endtask

   task automatic t_reset_state();
      logic [31:0] v;
      rd_reg(3'd1, v); check("R1 status", v, 32'h0);
      rd_reg(3'd2, v); check("R1 isr", v, 32'h0);
      rd_reg(3'd4, v); check("R1 total", v, 32'h0);
      check("R1 irq", {31'b0, irq}, 32'h0);
   endtask

   task automatic t_disabled();
      logic [31:0] v;
      wr_reg(3'd0, 32'd1);
      for (int i = 0; i < 4; i++) send_frame(8'hA0 + 8'(i), 1'b1);
      idle(40);
      rd_reg(3'd1, v); check("R2 disabled ignores", v, 32'h0);
   endtask

   task automatic t_pack();
      logic [31:0] v;
      wr_reg(3'd6, 32'd2);
      start_transfer(1'b1);
      send_frame(8'h81, 1'b1);
      send_frame(8'h22, 1'b1);
      send_frame(8'h3C, 1'b1);
      send_frame(8'hF4, 1'b1);
      idle(10);
      rd_reg(3'd1, v); check("R2 enabled not empty", v, 32'h5);
      rd_reg(3'd3, v); check("R3 packed order", v, 32'hF43C2281);
      rd_reg(3'd1, v); check("R3 drained", v, 32'h4);
   endtask

   task automatic t_stale_partial();
      logic [31:0] v;
      send_frame(8'h55, 1'b1);
      send_frame(8'h66, 1'b1);
      idle(100);
      rd_reg(3'd2, v); check("R4 not early", v, 32'h0);
      idle(500);
      rd_reg(3'd2, v); check("R4 stale set", v, 32'h1);
      check("R4 irq", {31'b0, irq}, 32'h1);
      rd_reg(3'd3, v); check("R5 zero fill", v, 32'h00006655);
      rd_reg(3'd4, v); check("R6 snapshot", v, 32'd6);
   endtask

   task automatic t_rearm();
      logic [31:0] v;
      wr_reg(3'd0, 32'd3);
      rd_reg(3'd2, v); check("R7 cleared", v, 32'h0);
      send_frame(8'h77, 1'b1);
      idle(700);
      rd_reg(3'd2, v); check("R7 no event unarmed", v, 32'h0);
      rd_reg(3'd4, v); check("R6 snapshot held", v, 32'd6);
      wr_reg(3'd0, 32'd4);
      send_frame(8'h88, 1'b1);
      idle(700);
      rd_reg(3'd2, v); check("R7 rearmed event", v, 32'h1);
      rd_reg(3'd4, v); check("R6 snapshot updated", v, 32'd8);
      rd_reg(3'd3, v); check("R5 two-byte flush", v, 32'h00008877);
   endtask

   task automatic t_no_byte_no_stale();
      logic [31:0] v;
      start_transfer(1'b1);
      idle(800);
      rd_reg(3'd2, v); check("R4 no byte no stale", v, 32'h0);
      rd_reg(3'd4, v); check("R10 total cleared", v, 32'h0);
   endtask

   task automatic t_reset_cmd();
      logic [31:0] v;
      start_transfer(1'b0);
      send_frame(8'h11, 1'b1);
      send_frame(8'h12, 1'b1);
      send_frame(8'h13, 1'b1);
      send_frame(8'h14, 1'b1);
      send_frame(8'h15, 1'b1);
      idle(10);
      rd_reg(3'd1, v); check("R10 before reset", v, 32'h5);
      wr_reg(3'd0, 32'd1);
      rd_reg(3'd1, v); check("R10 reset empties disables", v, 32'h0);
      wr_reg(3'd0, 32'd2);
      for (int i = 0; i < 4; i++) send_frame(8'h21 + 8'(i), 1'b1);
      idle(10);
      rd_reg(3'd3, v); check("R10 partial discarded", v, 32'h24232221);
   endtask

   task automatic t_overrun();
      logic [31:0] v;
      wr_reg(3'd5, 32'd2);
      start_transfer(1'b0);
      for (int k = 0; k < 9; k++) begin
         for (int j = 0; j < 4; j++) send_frame(8'(4 * k + j + 1), 1'b1);
         idle(4);
         if (k == 1) begin
            rd_reg(3'd2, v); check("R9 level equal wm", v, 32'h0);
         end
         if (k == 2) begin
            rd_reg(3'd2, v); check("R9 level above wm", v, 32'h2);
            check("R9 irq", {31'b0, irq}, 32'h1);
         end
         if (k == 7) begin
            rd_reg(3'd1, v); check("R8 full no overrun", v, 32'hD);
         end
      end
      rd_reg(3'd1, v); check("R8 overrun set", v, 32'hF);
      rd_reg(3'd3, v); check("R8 first word kept", v, 32'h04030201);
      for (int k = 1; k < 7; k++) rd_reg(3'd3, v);
      rd_reg(3'd3, v); check("R8 last stored word", v, 32'h201F1E1D);
      rd_reg(3'd1, v); check("R8 dropped word absent", v, 32'h6);
      wr_reg(3'd0, 32'd5);
      rd_reg(3'd1, v); check("R8 overrun cleared", v, 32'h4);
   endtask

   task automatic t_bad_stop();
      logic [31:0] v;
      start_transfer(1'b0);
      send_frame(8'hEE, 1'b0);
      for (int i = 0; i < 4; i++) send_frame(8'h31 + 8'(i), 1'b1);
      idle(10);
      rd_reg(3'd3, v); check("R11 bad stop dropped", v, 32'h34333231);
   endtask

   initial begin
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      idle(3);
      t_reset_state();
      t_disabled();
      t_pack();
      t_stale_partial();
      t_rearm();
      t_no_byte_no_stale();
      t_reset_cmd();
      t_overrun();
      t_bad_stop();
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule